// File: doc/BRIEF.md
# Interrupt destination resolver and dispatcher

This block takes one interrupt request from a pin servicer and turns it into delivery strobes towards a set of processor targets. The request carries a destination byte, an addressing mode (physical or logical), a delivery mode, a vector, a trigger-mode bit and the number of the pin that raised it. Each target reports a present flag, an 8-bit physical ID, an 8-bit logical ID and a priority value.

The resolver first builds the mask of addressed targets. It supports physical broadcast, physical unicast and logical group matching. The dispatcher then applies one of three policies to that mask: fixed delivery to all targets, lowest-priority delivery to one target, or non-maskable delivery. The result is registered once. A per-target strobe leaves the block together with the vector, the trigger mode and an NMI flag. In the same cycle, an accepted/unsupported response goes back to the pin servicer. A parameter enables a rule that routes pin 0 to target 0.

Top module: `irq_dispatch`

## Requirements
- R1: Physical mode (`req_logical_i`=0) with destination 0xFF addresses every present target.
- R2: Physical mode with any other destination addresses only the lowest-index present target whose physical ID equals the destination.
- R3: Logical mode (`req_logical_i`=1) with destination 0 addresses no target. Any other destination addresses every present target whose logical ID ANDed with the destination is nonzero.
- R4: When no target is addressed, no strobe is raised, `rsp_accepted_o` is 0 and `rsp_unsupported_o` is 0.
- R5: Fixed mode (`req_dmode_i`=000) strobes every addressed target. `dlv_vector_o` and `dlv_level_o` carry the request's vector and trigger bit, `dlv_nmi_o` is 0, and the request is accepted when at least one strobe is raised.
- R6: Lowest-priority mode (001) strobes exactly one addressed target. It picks the one with the smallest priority value, and a tie goes to the lowest index. The request is accepted.
- R7: NMI mode (100) strobes every addressed target with `dlv_nmi_o`=1, and the request is accepted.
- R8: Any other delivery mode with a non-empty address set raises `rsp_unsupported_o`, strobes nothing and is not accepted.
- R9: For pin 0 with a non-empty address set, fixed and lowest-priority modes strobe target 0 alone, provided it is present. The request is accepted only if that strobe is raised.
- R10: All outputs appear in the cycle after `req_valid_i` is sampled, for one cycle only. With no request, `rsp_valid_o` and every strobe are 0.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_pin_i | input | PIN_W | Pin number that raised the request |
| req_dest_i | input | ID_W | Destination byte |
| req_logical_i | input | 1 | 1 = logical addressing, 0 = physical |
| req_dmode_i | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, 100 NMI |
| req_vector_i | input | VEC_W | Interrupt vector |
| req_level_i | input | 1 | Trigger mode, 1 = level |
| tgt_present_i | input | N_TGT | Per-target present flag |
| tgt_phys_id_i | input | N_TGT*ID_W | Packed physical IDs, target i at [i*ID_W +: ID_W] |
| tgt_log_id_i | input | N_TGT*ID_W | Packed logical IDs |
| tgt_prio_i | input | N_TGT*PRIO_W | Packed priority values, smaller wins |
| dlv_strobe_o | output | N_TGT | Per-target delivery strobe |
| dlv_vector_o | output | VEC_W | Delivered vector |
| dlv_level_o | output | 1 | Delivered trigger mode |
| dlv_nmi_o | output | 1 | Delivery is non-maskable |
| rsp_valid_o | output | 1 | Response to the pin servicer is valid |
| rsp_accepted_o | output | 1 | Request was delivered |
| rsp_unsupported_o | output | 1 | Delivery mode not supported |

## Verification
Each request is applied for one cycle. Every result (strobes, vector, trigger, NMI flag and the response) is due in the cycle right after the request edge, with one register stage on the way. The bench drives on the falling edge, lets one rising edge pass and samples on the next falling edge. On the falling edge after that, it checks that the outputs have returned to zero. The same stimulus goes to a bench model built from the requirements, so every field is compared in the single cycle where it is due.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWEST = 3'b001,
    DM_NMI    = 3'b100
  } dmode_e;
endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int N_TGT = 4,
  parameter int ID_W  = 8
) (
  input  logic [ID_W-1:0]       dest_i,
  input  logic                  logical_i,
  input  logic [N_TGT-1:0]      present_i,
  input  logic [N_TGT*ID_W-1:0] phys_id_i,
  input  logic [N_TGT*ID_W-1:0] log_id_i,
  output logic [N_TGT-1:0]      mask_o
);
  logic [N_TGT-1:0] phys_hit, log_hit, phys_first;
  logic             bcast;

  assign bcast = (dest_i == {ID_W{1'b1}});

  for (genvar g = 0; g < N_TGT; g++) begin : g_hit
    assign phys_hit[g] = present_i[g] && (phys_id_i[g*ID_W +: ID_W] == dest_i);
    assign log_hit[g]  = present_i[g] && |(log_id_i[g*ID_W +: ID_W] & dest_i);
  end

  // first matching target only
  always_comb begin
    phys_first = '0;
    for (int i = N_TGT-1; i >= 0; i--)
      if (phys_hit[i]) begin
        phys_first    = '0;
        phys_first[i] = 1'b1;
      end
  end

  always_comb begin
    if (logical_i)  mask_o = (dest_i == '0) ? '0 : log_hit;
    else if (bcast) mask_o = present_i;
    else            mask_o = phys_first;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_TGT  = 4,
  parameter int PRIO_W = 4
) (
  input  logic [N_TGT-1:0]        mask_i,
  input  logic [N_TGT*PRIO_W-1:0] prio_i,
  output logic [N_TGT-1:0]        pick_o
);
  logic [PRIO_W-1:0] best;
  logic              found;

  // strict less-than keeps the lowest index on ties
  always_comb begin
    pick_o = '0;
    best   = '0;
    found  = 1'b0;
    for (int i = 0; i < N_TGT; i++) begin
      if (mask_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
        best      = prio_i[i*PRIO_W +: PRIO_W];
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_policy.sv
module irq_dispatch_policy
  import irq_dispatch_pkg::*;
#(
  parameter int N_TGT = 4
) (
  input  logic [2:0]       dmode_i,
  input  logic             pin_zero_i,
  input  logic [N_TGT-1:0] mask_i,
  input  logic [N_TGT-1:0] pick_i,
  input  logic             present0_i,
  output logic [N_TGT-1:0] strobe_o,
  output logic             nmi_o,
  output logic             accepted_o,
  output logic             unsupported_o
);
  logic [N_TGT-1:0] tgt0_only;

  always_comb begin
    tgt0_only    = '0;
    tgt0_only[0] = present0_i;
  end

  always_comb begin
    strobe_o      = '0;
    nmi_o         = 1'b0;
    unsupported_o = 1'b0;
    if (mask_i != '0) begin
      case (dmode_i)
        DM_FIXED:  strobe_o = pin_zero_i ? tgt0_only : mask_i;
        DM_LOWEST: strobe_o = pin_zero_i ? tgt0_only : pick_i;
        DM_NMI: begin
          strobe_o = mask_i;
          nmi_o    = 1'b1;
        end
        default:   unsupported_o = 1'b1;
      endcase
    end
    accepted_o = |strobe_o;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int N_TGT      = 4,
  parameter int ID_W       = 8,
  parameter int VEC_W      = 8,
  parameter int PRIO_W     = 4,
  parameter int PIN_W      = 5,
  parameter bit FORCE_PIN0 = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [PIN_W-1:0]        req_pin_i,
  input  logic [ID_W-1:0]         req_dest_i,
  input  logic                    req_logical_i,
  input  logic [2:0]              req_dmode_i,
  input  logic [VEC_W-1:0]        req_vector_i,
  input  logic                    req_level_i,
  input  logic [N_TGT-1:0]        tgt_present_i,
  input  logic [N_TGT*ID_W-1:0]   tgt_phys_id_i,
  input  logic [N_TGT*ID_W-1:0]   tgt_log_id_i,
  input  logic [N_TGT*PRIO_W-1:0] tgt_prio_i,
  output logic [N_TGT-1:0]        dlv_strobe_o,
  output logic [VEC_W-1:0]        dlv_vector_o,
  output logic                    dlv_level_o,
  output logic                    dlv_nmi_o,
  output logic                    rsp_valid_o,
  output logic                    rsp_accepted_o,
  output logic                    rsp_unsupported_o
);
  logic [N_TGT-1:0] mask, pick, strobe;
  logic             pin_zero, nmi, accepted, unsupported;

  if (FORCE_PIN0) begin : g_pin0
    assign pin_zero = (req_pin_i == '0);
  end else begin : g_no_pin0
    assign pin_zero = 1'b0;
  end

  irq_dest_match #(.N_TGT(N_TGT), .ID_W(ID_W)) i_match (
    .dest_i    (req_dest_i),
    .logical_i (req_logical_i),
    .present_i (tgt_present_i),
    .phys_id_i (tgt_phys_id_i),
    .log_id_i  (tgt_log_id_i),
    .mask_o    (mask)
  );

  irq_lowest_pick #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) i_pick (
    .mask_i (mask),
    .prio_i (tgt_prio_i),
    .pick_o (pick)
  );

  irq_dispatch_policy #(.N_TGT(N_TGT)) i_policy (
    .dmode_i       (req_dmode_i),
    .pin_zero_i    (pin_zero),
    .mask_i        (mask),
    .pick_i        (pick),
    .present0_i    (tgt_present_i[0]),
    .strobe_o      (strobe),
    .nmi_o         (nmi),
    .accepted_o    (accepted),
    .unsupported_o (unsupported)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_strobe_o      <= '0;
      dlv_vector_o      <= '0;
      dlv_level_o       <= 1'b0;
      dlv_nmi_o         <= 1'b0;
      rsp_valid_o       <= 1'b0;
      rsp_accepted_o    <= 1'b0;
      rsp_unsupported_o <= 1'b0;
    end else begin
      rsp_valid_o       <= req_valid_i;
      dlv_strobe_o      <= req_valid_i ? strobe : '0;
      dlv_vector_o      <= req_valid_i ? req_vector_i : '0;
      dlv_level_o       <= req_valid_i && req_level_i;
      dlv_nmi_o         <= req_valid_i && nmi;
      rsp_accepted_o    <= req_valid_i && accepted;
      rsp_unsupported_o <= req_valid_i && unsupported;
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_dispatch_pkg::*;
#(
  parameter int N_TGT  = 4,
  parameter int ID_W   = 8,
  parameter int VEC_W  = 8,
  parameter int PRIO_W = 4,
  parameter int PIN_W  = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [PIN_W-1:0]        req_pin_i,
  input logic [ID_W-1:0]         req_dest_i,
  input logic                    req_logical_i,
  input logic [2:0]              req_dmode_i,
  input logic [N_TGT-1:0]        tgt_present_i,
  input logic [N_TGT-1:0]        dlv_strobe_o,
  input logic                    dlv_nmi_o,
  input logic                    rsp_valid_o,
  input logic                    rsp_accepted_o,
  input logic                    rsp_unsupported_o
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && dlv_strobe_o == '0));

  // R1
  strobe_present_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ((dlv_strobe_o & ~$past(tgt_present_i)) == '0));

  // R3
  logical_zero_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_logical_i) && $past(req_dest_i) == '0)
      |-> (dlv_strobe_o == '0 && !rsp_accepted_o));

  // R6
  lowest_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_dmode_i) == DM_LOWEST) |-> $onehot0(dlv_strobe_o));

  // R7
  nmi_accepted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_nmi_o |-> (rsp_accepted_o && $past(req_dmode_i) == DM_NMI));

  // R8
  unsupported_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_unsupported_o |-> (dlv_strobe_o == '0 && !rsp_accepted_o && !dlv_nmi_o));

  // R9
  pin0_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_pin_i) == '0 && $past(req_dmode_i) == DM_FIXED)
      |-> (dlv_strobe_o[N_TGT-1:1] == '0));
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .N_TGT(N_TGT), .ID_W(ID_W), .VEC_W(VEC_W), .PRIO_W(PRIO_W), .PIN_W(PIN_W)
) i_chk (.*);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [4:0]     req_pin = '0;
  logic [7:0]     req_dest = '0;
  logic           req_logical = 1'b0;
  logic [2:0]     req_dmode = '0;
  logic [7:0]     req_vector = '0;
  logic           req_level = 1'b0;
  logic [N-1:0]   pres = '0;
  logic [N*8-1:0] pid = '0;
  logic [N*8-1:0] lid = '0;
  logic [N*4-1:0] pr = '0;
  logic [N-1:0]   strobe;
  logic [7:0]     vec_o;
  logic           lvl_o, nmi_o, rsp_v, acc_o, uns_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_dispatch i_irq_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_pin_i(req_pin),
    .req_dest_i(req_dest), .req_logical_i(req_logical), .req_dmode_i(req_dmode),
    .req_vector_i(req_vector), .req_level_i(req_level), .tgt_present_i(pres),
    .tgt_phys_id_i(pid), .tgt_log_id_i(lid), .tgt_prio_i(pr),
    .dlv_strobe_o(strobe), .dlv_vector_o(vec_o), .dlv_level_o(lvl_o),
    .dlv_nmi_o(nmi_o), .rsp_valid_o(rsp_v), .rsp_accepted_o(acc_o),
    .rsp_unsupported_o(uns_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_mask(logic [7:0] d, logic lg);
    logic [N-1:0] m = '0;
    if (lg) begin
      if (d != 0)
        for (int i = 0; i < N; i++)
          if (pres[i] && (lid[i*8 +: 8] & d) != 0) m[i] = 1'b1;
    end else if (d == 8'hFF) begin
      m = pres;
    end else begin
      for (int i = 0; i < N; i++)
        if (pres[i] && pid[i*8 +: 8] == d && m == '0) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [N-1:0] exp_lowest(logic [N-1:0] m);
    logic [N-1:0] s = '0;
    int best = 99;
    for (int i = 0; i < N; i++)
      if (m[i] && int'(pr[i*4 +: 4]) < best) begin
        best = int'(pr[i*4 +: 4]);
        s = '0;
        s[i] = 1'b1;
      end
    return s;
  endfunction

  // one request: drive, wait one rising edge, sample, then check idle return
  task automatic run(logic [4:0] pin, logic [7:0] d, logic lg, logic [2:0] dm,
                     logic [7:0] v, logic lv);
    logic [N-1:0] m, s;
    logic nmi_e, uns_e;
    string tag;
    m = exp_mask(d, lg);
    s = '0; nmi_e = 1'b0; uns_e = 1'b0;
    tag = lg ? "R3" : (d == 8'hFF ? "R1" : "R2");
    if (m == '0) tag = {tag, "/R4"};
    else if (pin == 0 && (dm == 3'b000 || dm == 3'b001)) begin
      s[0] = pres[0]; tag = {tag, "/R9"};
    end else case (dm)
      3'b000: begin s = m; tag = {tag, "/R5"}; end
      3'b001: begin s = exp_lowest(m); tag = {tag, "/R6"}; end
      3'b100: begin s = m; nmi_e = 1'b1; tag = {tag, "/R7"}; end
      default: begin uns_e = 1'b1; tag = {tag, "/R8"}; end
    endcase
    @(negedge clk);
    req_pin = pin; req_dest = d; req_logical = lg; req_dmode = dm;
    req_vector = v; req_level = lv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " strobe"}, 32'(strobe), 32'(s));
    chk({tag, " accepted"}, 32'(acc_o), 32'(s != '0));
    chk({tag, " unsupported"}, 32'(uns_o), 32'(uns_e));
    chk({tag, " nmi"}, 32'(nmi_o), 32'(nmi_e));
    chk("R5 vector", 32'(vec_o), 32'(v));
    chk("R5 level", 32'(lvl_o), 32'(lv));
    chk("R10 rsp_valid", 32'(rsp_v), 32'd1);
    @(negedge clk);
    chk("R10 idle", 32'({rsp_v, strobe, acc_o, nmi_o}), 32'd0);
  endtask

  function automatic void set_tgt(int i, logic p, logic [7:0] ph, logic [7:0] lg, logic [3:0] q);
    pres[i] = p; pid[i*8 +: 8] = ph; lid[i*8 +: 8] = lg; pr[i*4 +: 4] = q;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset", 32'({strobe, vec_o, lvl_o, nmi_o, rsp_v, acc_o, uns_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    set_tgt(0, 1, 8'h00, 8'h01, 4'd3);
    set_tgt(1, 0, 8'h05, 8'h02, 4'd1);
    set_tgt(2, 1, 8'h02, 8'h06, 4'd2);
    set_tgt(3, 1, 8'h05, 8'h0C, 4'd2);
    run(5'd3, 8'hFF, 0, 3'b100, 8'h21, 0);   // R1 broadcast NMI
    run(5'd3, 8'h05, 0, 3'b000, 8'h30, 1);   // R2 absent match skipped, target 3
    run(5'd3, 8'h00, 1, 3'b000, 8'h31, 0);   // R3 logical dest zero
    run(5'd3, 8'h06, 1, 3'b000, 8'h32, 1);   // R3/R5 group
    run(5'd3, 8'h0C, 1, 3'b001, 8'h33, 0);   // R6 tie -> target 2
    run(5'd3, 8'h77, 0, 3'b000, 8'h34, 0);   // R4 empty
    run(5'd3, 8'h77, 0, 3'b010, 8'h34, 0);   // R4 empty before unsupported
    run(5'd3, 8'hFF, 0, 3'b111, 8'h35, 0);   // R8
    run(5'd0, 8'h0C, 1, 3'b000, 8'h36, 0);   // R9 fixed to target 0
    run(5'd0, 8'h0C, 1, 3'b100, 8'h37, 0);   // R9 does not affect NMI
    pres[0] = 1'b0;
    run(5'd0, 8'hFF, 0, 3'b001, 8'h38, 1);   // R9 target 0 absent

    for (int k = 0; k < 400; k++) begin
      logic [2:0] modes [5] = '{3'b000, 3'b001, 3'b100, 3'b010, 3'b111};
      logic [7:0] d;
      for (int i = 0; i < N; i++)
        set_tgt(i, 1'($urandom), 8'($urandom_range(0, 3)), 8'($urandom),
                4'($urandom_range(0, 3)));
      case ($urandom_range(0, 3))
        0: d = 8'hFF;
        1: d = 8'($urandom_range(0, 3));
        2: d = 8'h00;
        default: d = 8'($urandom);
      endcase
      run(5'($urandom_range(0, 3)), d, 1'($urandom), modes[$urandom_range(0, 4)],
          8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule